// File: doc/BRIEF.md
# Program Status Flag Update Unit

This block owns the carry (CY), overflow (OV) and auxiliary-carry (AC) bits of the status word in an 8-bit accumulator CPU. The decoder supplies an instruction class code. The datapath supplies the two operand bytes and a selected bit value. Each cycle in which `retire` is high, the unit works out new flag values for that class and writes only the flags the class may touch. The other flags keep their value.

Each class carries its own write mask, and some classes force a value. Arithmetic classes rewrite all three flags. Multiply and divide clear CY, set OV and leave AC as it is. Decimal adjust, the rotates, the boolean-carry operations and compare-and-jump write CY only. ADDC and SUBB take the current CY as their carry or borrow input. Decimal adjust reads the current CY and AC. Software can overwrite all three flags through a direct register write port. That write wins over any retiring instruction in the same cycle.

Top module: `psw_flag_unit`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `cy`, `ac` and `ov` are 0.
- R2: For `op_class` 1 (add) and 2 (add with carry, carry-in = current CY; add uses carry-in 0), CY is the carry out of bit 7, AC is the carry out of bit 3, and OV is set when the signed sum of the two operands and the carry-in falls outside -128..127.
- R3: For `op_class` 3 (subtract with borrow, borrow-in = current CY), CY is the borrow out of bit 7, AC is the borrow out of bit 3, and OV is set when the signed difference falls outside -128..127.
- R4: For `op_class` 4 (multiply), CY becomes 0, OV is set when the unsigned product of the operands exceeds 255, and AC is unchanged.
- R5: For `op_class` 5 (divide), CY becomes 0, OV is set when `opnd_b` is 0, and AC is unchanged.
- R6: For `op_class` 6 (decimal adjust of `opnd_a`), first add 6 when the low nibble exceeds 9 or AC is set. CY then becomes 1 when this add carries out of bit 7, when the resulting upper nibble exceeds 9, or when CY was already 1. CY is never cleared. OV and AC are unchanged.
- R7: For `op_class` 7 (rotate left through carry) CY takes `opnd_a[7]`. For 8 (rotate right through carry) CY takes `opnd_a[0]`. OV and AC are unchanged.
- R8: For `op_class` 9 CY becomes 1, for 10 CY becomes 0, and for 11 CY is inverted. OV and AC are unchanged.
- R9: With b = `bit_in`, CY becomes b for `op_class` 12, CY&b for 13, CY&~b for 14, CY|b for 15 and CY|~b for 16. OV and AC are unchanged.
- R10: For `op_class` 17 (compare), CY becomes 1 exactly when `opnd_a` < `opnd_b` unsigned. OV and AC are unchanged.
- R11: When `sfr_we` is high, the next state is `sfr_wdata` (bit 2 = CY, bit 1 = AC, bit 0 = OV). This holds whatever `retire` and `op_class` are.
- R12: When `retire` is low, or `op_class` is 0 or above 17, all three flags keep their value (unless R11 applies).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| retire | input | 1 | An instruction completes this cycle |
| op_class | input | 5 | Decoded instruction class (codes in R2 to R12) |
| opnd_a | input | 8 | First operand (accumulator) |
| opnd_b | input | 8 | Second operand |
| bit_in | input | 1 | Selected bit for boolean-carry classes |
| sfr_we | input | 1 | Direct write of the flag register |
| sfr_wdata | input | 3 | Write data {CY, AC, OV} |
| cy | output | 1 | Carry flag |
| ac | output | 1 | Auxiliary-carry flag |
| ov | output | 1 | Overflow flag |

## Verification
Some properties hold every cycle, and the bound checker watches them all the time. These are: the register write beating an instruction, idle and unknown classes holding the flags, multiply/divide clearing CY while AC stays put, every CY-only class leaving OV and AC alone, decimal adjust never dropping a set CY, set-carry, and the compare result. Other results can only be shown by the bench's scenarios, because they depend on chosen operand values. These are the exact carry, half-carry and signed-overflow values of add and subtract, the multiply-overflow threshold at 255/256, and the nibble-dependent outcomes of decimal adjust. A long random sequence against the reference model then checks how state carries from ADDC, SUBB and decimal adjust into later instructions.

// File: rtl/psw_flag_pkg.sv
package psw_flag_pkg;

   localparam int OP_W = 5;

   typedef enum logic [OP_W-1:0] {
      OPC_NOP   = 5'd0,
      OPC_ADD   = 5'd1,
      OPC_ADDC  = 5'd2,
      OPC_SUBB  = 5'd3,
      OPC_MUL   = 5'd4,
      OPC_DIV   = 5'd5,
      OPC_DA    = 5'd6,
      OPC_RLC   = 5'd7,
      OPC_RRC   = 5'd8,
      OPC_SETC  = 5'd9,
      OPC_CLRC  = 5'd10,
      OPC_CPLC  = 5'd11,
      OPC_MOVC  = 5'd12,
      OPC_ANLC  = 5'd13,
      OPC_ANLCN = 5'd14,
      OPC_ORLC  = 5'd15,
      OPC_ORLCN = 5'd16,
      OPC_CJNE  = 5'd17
   } op_class_e;

   localparam int OPC_LAST = 17;

   // Packed order matches the register write data: {cy, ac, ov}
   typedef struct packed {
      logic cy;
      logic ac;
      logic ov;
   } psw_flags_t;

endpackage

// File: rtl/psw_addsub_flags.sv
// Carry/borrow terms for add and subtract at the nibble, sign-1 and sign
// positions. SHARED_ADDER picks one adder with inverted operand versus two
// separate add and subtract chains.
module psw_addsub_flags #(
   parameter int DATA_W       = 8,
   parameter int NIB_W        = 4,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              cin,
   input  logic              sub,
   output logic              cy_o,
   output logic              ac_o,
   output logic              ov_o
);

   localparam int LOW_W = DATA_W - 1;

   logic [NIB_W:0]  lo_r;
   logic [LOW_W:0]  mid_r;
   logic [DATA_W:0] full_r;

   generate
      if (SHARED_ADDER) begin : g_shared
         logic [DATA_W-1:0] b_eff;
         logic              c_eff;
         assign b_eff = sub ? ~b : b;
         assign c_eff = sub ? ~cin : cin;
         always_comb begin
            lo_r   = {1'b0, a[NIB_W-1:0]} + {1'b0, b_eff[NIB_W-1:0]}
                   + {{NIB_W{1'b0}}, c_eff};
            mid_r  = {1'b0, a[LOW_W-1:0]} + {1'b0, b_eff[LOW_W-1:0]}
                   + {{LOW_W{1'b0}}, c_eff};
            full_r = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, c_eff};
         end
         // in subtract mode a missing carry is a borrow
         assign cy_o = full_r[DATA_W] ^ sub;
         assign ac_o = lo_r[NIB_W] ^ sub;
         assign ov_o = mid_r[LOW_W] ^ full_r[DATA_W];
      end else begin : g_split
         logic [NIB_W:0]  lo_add, lo_sub;
         logic [LOW_W:0]  mid_add, mid_sub;
         logic [DATA_W:0] full_add, full_sub;
         always_comb begin
            lo_add   = {1'b0, a[NIB_W-1:0]} + {1'b0, b[NIB_W-1:0]}
                     + {{NIB_W{1'b0}}, cin};
            lo_sub   = {1'b0, a[NIB_W-1:0]} - {1'b0, b[NIB_W-1:0]}
                     - {{NIB_W{1'b0}}, cin};
            mid_add  = {1'b0, a[LOW_W-1:0]} + {1'b0, b[LOW_W-1:0]}
                     + {{LOW_W{1'b0}}, cin};
            mid_sub  = {1'b0, a[LOW_W-1:0]} - {1'b0, b[LOW_W-1:0]}
                     - {{LOW_W{1'b0}}, cin};
            full_add = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};
            full_sub = {1'b0, a} - {1'b0, b} - {{DATA_W{1'b0}}, cin};
            lo_r     = sub ? lo_sub   : lo_add;
            mid_r    = sub ? mid_sub  : mid_add;
            full_r   = sub ? full_sub : full_add;
         end
         assign cy_o = full_r[DATA_W];
         assign ac_o = lo_r[NIB_W];
         assign ov_o = mid_r[LOW_W] ^ full_r[DATA_W];
      end
   endgenerate

endmodule

// File: rtl/psw_rule_unit.sv
// Per-class flag rules: candidate values plus a write mask.
module psw_rule_unit
   import psw_flag_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int NIB_W  = 4
) (
   input  logic [OP_W-1:0]   op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              bit_in,
   input  psw_flags_t        cur,
   input  logic              as_cy,
   input  logic              as_ac,
   input  logic              as_ov,
   output psw_flags_t        nxt,
   output psw_flags_t        msk
);

   localparam int PROD_W = 2 * DATA_W;
   localparam int BYTE_W = 2 * NIB_W;
   localparam logic [NIB_W-1:0] BCD_MAX = NIB_W'(9);

   logic [PROD_W-1:0] prod;
   logic              mul_ov;
   logic              div_ov;
   logic [BYTE_W:0]   da_sum;
   logic              da_lo_fix;
   logic              da_cy;
   logic              lt;

   assign prod   = {{DATA_W{1'b0}}, a} * {{DATA_W{1'b0}}, b};
   assign mul_ov = |prod[PROD_W-1:DATA_W];
   assign div_ov = (b == '0);
   assign lt     = (a < b);

   // decimal adjust on the low byte of the operand
   assign da_lo_fix = (a[NIB_W-1:0] > BCD_MAX) || cur.ac;
   assign da_sum    = {1'b0, a[BYTE_W-1:0]}
                    + (da_lo_fix ? (BYTE_W+1)'(6) : '0);
   assign da_cy     = cur.cy | da_sum[BYTE_W]
                    | (da_sum[BYTE_W-1:NIB_W] > BCD_MAX);

   always_comb begin
      nxt = cur;
      msk = '0;
      case (op)
         OPC_ADD, OPC_ADDC, OPC_SUBB: begin
            nxt.cy = as_cy;
            nxt.ac = as_ac;
            nxt.ov = as_ov;
            msk    = '1;
         end
         OPC_MUL: begin
            nxt.cy = 1'b0;
            nxt.ov = mul_ov;
            msk.cy = 1'b1;
            msk.ov = 1'b1;
         end
         OPC_DIV: begin
            nxt.cy = 1'b0;
            nxt.ov = div_ov;
            msk.cy = 1'b1;
            msk.ov = 1'b1;
         end
         OPC_DA: begin
            nxt.cy = da_cy;
            msk.cy = 1'b1;
         end
         OPC_RLC: begin
            nxt.cy = a[DATA_W-1];
            msk.cy = 1'b1;
         end
         OPC_RRC: begin
            nxt.cy = a[0];
            msk.cy = 1'b1;
         end
         OPC_SETC: begin
            nxt.cy = 1'b1;
            msk.cy = 1'b1;
         end
         OPC_CLRC: begin
            nxt.cy = 1'b0;
            msk.cy = 1'b1;
         end
         OPC_CPLC: begin
            nxt.cy = ~cur.cy;
            msk.cy = 1'b1;
         end
         OPC_MOVC: begin
            nxt.cy = bit_in;
            msk.cy = 1'b1;
         end
         OPC_ANLC: begin
            nxt.cy = cur.cy & bit_in;
            msk.cy = 1'b1;
         end
         OPC_ANLCN: begin
            nxt.cy = cur.cy & ~bit_in;
            msk.cy = 1'b1;
         end
         OPC_ORLC: begin
            nxt.cy = cur.cy | bit_in;
            msk.cy = 1'b1;
         end
         OPC_ORLCN: begin
            nxt.cy = cur.cy | ~bit_in;
            msk.cy = 1'b1;
         end
         OPC_CJNE: begin
            nxt.cy = lt;
            msk.cy = 1'b1;
         end
         default: begin
            nxt = cur;
            msk = '0;
         end
      endcase
   end

endmodule

// File: rtl/psw_flag_reg.sv
// Flag storage: register write first, then masked instruction update.
module psw_flag_reg
   import psw_flag_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       upd_en,
   input  psw_flags_t upd_val,
   input  psw_flags_t upd_msk,
   input  logic       wr_en,
   input  psw_flags_t wr_val,
   output psw_flags_t q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q <= '0;
      end else if (wr_en) begin
         q <= wr_val;
      end else if (upd_en) begin
         q <= (q & ~upd_msk) | (upd_val & upd_msk);
      end
   end

endmodule

// File: rtl/psw_flag_unit.sv
module psw_flag_unit
   import psw_flag_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter int NIB_W        = 4,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              retire,
   input  logic [OP_W-1:0]   op_class,
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   input  logic              bit_in,
   input  logic              sfr_we,
   input  logic [2:0]        sfr_wdata,
   output logic              cy,
   output logic              ac,
   output logic              ov
);

   generate
      if (NIB_W < 2 || DATA_W < 2 * NIB_W) begin : g_bad_width
         $error("psw_flag_unit: DATA_W must hold two nibbles of NIB_W >= 2");
      end
      if ($bits(psw_flags_t) != 3) begin : g_bad_flags
         $error("psw_flag_unit: flag word must be three bits");
      end
   endgenerate

   psw_flags_t cur, nxt, msk;
   logic       as_cy, as_ac, as_ov;
   logic       is_sub;
   logic       add_cin;

   assign is_sub  = (op_class == OPC_SUBB);
   assign add_cin = (op_class == OPC_ADD) ? 1'b0 : cur.cy;

   psw_addsub_flags #(
      .DATA_W       (DATA_W),
      .NIB_W        (NIB_W),
      .SHARED_ADDER (SHARED_ADDER)
   ) u_addsub (
      .a    (opnd_a),
      .b    (opnd_b),
      .cin  (add_cin),
      .sub  (is_sub),
      .cy_o (as_cy),
      .ac_o (as_ac),
      .ov_o (as_ov)
   );

   psw_rule_unit #(
      .DATA_W (DATA_W),
      .NIB_W  (NIB_W)
   ) u_rules (
      .op     (op_class),
      .a      (opnd_a),
      .b      (opnd_b),
      .bit_in (bit_in),
      .cur    (cur),
      .as_cy  (as_cy),
      .as_ac  (as_ac),
      .as_ov  (as_ov),
      .nxt    (nxt),
      .msk    (msk)
   );

   psw_flag_reg u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .upd_en  (retire),
      .upd_val (nxt),
      .upd_msk (msk),
      .wr_en   (sfr_we),
      .wr_val  (psw_flags_t'(sfr_wdata)),
      .q       (cur)
   );

   assign cy = cur.cy;
   assign ac = cur.ac;
   assign ov = cur.ov;

endmodule

// File: rtl/psw_flag_unit_chk.sv
module psw_flag_unit_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              retire,
   input logic [4:0]        op_class,
   input logic [DATA_W-1:0] opnd_a,
   input logic [DATA_W-1:0] opnd_b,
   input logic              sfr_we,
   input logic [2:0]        sfr_wdata,
   input logic              cy,
   input logic              ac,
   input logic              ov
);

   logic live;
   assign live = retire && !sfr_we;

   // R11: register write beats any instruction
   a_r11_sfr_wins: assert property (@(posedge clk) disable iff (!rst_n)
      sfr_we |=> ({cy, ac, ov} == $past(sfr_wdata)));

   // R12: idle or unknown class holds every flag
   a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!sfr_we && (!retire || op_class == 5'd0 || op_class > 5'd17))
      |=> $stable({cy, ac, ov}));

   // R4 / R5: multiply and divide clear CY, keep AC
   a_r4_muldiv_cy_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (live && (op_class == 5'd4 || op_class == 5'd5))
      |=> (!cy && $stable(ac)));

   // R5: divide by zero raises OV
   a_r5_div_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (live && op_class == 5'd5 && opnd_b == '0) |=> ov);

   // R6: decimal adjust never drops a set CY
   a_r6_da_keeps_cy: assert property (@(posedge clk) disable iff (!rst_n)
      (live && op_class == 5'd6 && cy) |=> cy);

   // R9 (and R6, R7, R8, R10): CY-only classes leave OV and AC alone
   a_r9_cy_only_classes: assert property (@(posedge clk) disable iff (!rst_n)
      (live && op_class >= 5'd6 && op_class <= 5'd17)
      |=> ($stable(ac) && $stable(ov)));

   // R8: set-carry
   a_r8_set_carry: assert property (@(posedge clk) disable iff (!rst_n)
      (live && op_class == 5'd9) |=> cy);

   // R10: compare drives CY from unsigned less-than
   a_r10_compare: assert property (@(posedge clk) disable iff (!rst_n)
      (live && op_class == 5'd17) |=> (cy == ($past(opnd_a) < $past(opnd_b))));

endmodule

bind psw_flag_unit psw_flag_unit_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .retire    (retire),
   .op_class  (op_class),
   .opnd_a    (opnd_a),
   .opnd_b    (opnd_b),
   .sfr_we    (sfr_we),
   .sfr_wdata (sfr_wdata),
   .cy        (cy),
   .ac        (ac),
   .ov        (ov)
);

// File: tb/psw_flag_unit_test.sv
`timescale 1ns/1ps
module psw_flag_unit_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       retire = 1'b0;
   logic [4:0] op_class = '0;
   logic [7:0] opnd_a = '0;
   logic [7:0] opnd_b = '0;
   logic       bit_in = 1'b0;
   logic       sfr_we = 1'b0;
   logic [2:0] sfr_wdata = '0;
   logic       cy, ac, ov;

   int vectors = 0;
   int miscompares = 0;
   logic [2:0] mdl = '0;   // {cy, ac, ov}

   typedef struct {
      logic [2:0] exp;
      string      tag;
   } sb_item_t;
   sb_item_t sb_q[$];

   always #10 clk = ~clk;   // 50 MHz

   psw_flag_unit uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .retire    (retire),
      .op_class  (op_class),
      .opnd_a    (opnd_a),
      .opnd_b    (opnd_b),
      .bit_in    (bit_in),
      .sfr_we    (sfr_we),
      .sfr_wdata (sfr_wdata),
      .cy        (cy),
      .ac        (ac),
      .ov        (ov)
   );

   function automatic int sx(input logic [7:0] v);
      return (v > 8'd127) ? int'(v) - 256 : int'(v);
   endfunction

   function automatic logic [2:0] model(input logic [4:0] op, input logic [7:0] a,
         input logic [7:0] b, input logic bv, input logic ret, input logic we,
         input logic [2:0] wd, input logic [2:0] st);
      logic c, h, o;
      int   ci, r, sr, t;
      c = st[2]; h = st[1]; o = st[0];
      if (we) return wd;
      if (!ret) return st;
      case (op)
         5'd1, 5'd2: begin
            ci = (op == 5'd2) ? int'(c) : 0;
            r  = int'(a) + int'(b) + ci;
            sr = sx(a) + sx(b) + ci;
            c  = (r > 255);
            h  = ((int'(a) % 16) + (int'(b) % 16) + ci) > 15;
            o  = (sr > 127) || (sr < -128);
         end
         5'd3: begin
            ci = int'(c);
            r  = int'(a) - int'(b) - ci;
            sr = sx(a) - sx(b) - ci;
            c  = (r < 0);
            h  = ((int'(a) % 16) - (int'(b) % 16) - ci) < 0;
            o  = (sr > 127) || (sr < -128);
         end
         5'd4: begin c = 1'b0; o = (int'(a) * int'(b)) > 255; end
         5'd5: begin c = 1'b0; o = (b == 8'd0); end
         5'd6: begin
            t = int'(a);
            if ((int'(a) % 16) > 9 || h) t = t + 6;
            c = c || (t > 255) || (((t / 16) % 16) > 9);
         end
         5'd7:  c = a[7];
         5'd8:  c = a[0];
         5'd9:  c = 1'b1;
         5'd10: c = 1'b0;
         5'd11: c = !c;
         5'd12: c = bv;
         5'd13: c = c && bv;
         5'd14: c = c && !bv;
         5'd15: c = c || bv;
         5'd16: c = c || !bv;
         5'd17: c = (a < b);
         default: ;
      endcase
      return {c, h, o};
   endfunction

   task automatic step(input logic [4:0] op, input logic [7:0] a, input logic [7:0] b,
         input logic bv, input logic ret, input logic we, input logic [2:0] wd,
         input string tag);
      sb_item_t it;
      @(negedge clk);
      op_class = op; opnd_a = a; opnd_b = b; bit_in = bv;
      retire = ret; sfr_we = we; sfr_wdata = wd;
      mdl = model(op, a, b, bv, ret, we, wd, mdl);
      it.exp = mdl;
      it.tag = tag;
      sb_q.push_back(it);
   endtask

   task automatic run(input logic [4:0] op, input logic [7:0] a, input logic [7:0] b,
         input string tag);
      step(op, a, b, 1'b0, 1'b1, 1'b0, 3'b000, tag);
   endtask

   task automatic wr(input logic [2:0] wd);
      step(5'd0, 8'd0, 8'd0, 1'b0, 1'b0, 1'b1, wd, "R11");
   endtask

   // monitor
   initial begin
      sb_item_t it;
      forever begin
         @(posedge clk);
         #1;
         if (sb_q.size() > 0) begin
            it = sb_q.pop_front();
            vectors++;
            if ({cy, ac, ov} !== it.exp) begin
               miscompares++;
               $display("FAIL %s: {cy,ac,ov} actual=%b expected=%b", it.tag, {cy, ac, ov}, it.exp);
            end
         end
      end
   end

   // watchdog
   initial begin
      repeat (100000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      // R1: reset state
      repeat (3) @(posedge clk);
      #1;
      vectors++;
      if ({cy, ac, ov} !== 3'b000) begin
         miscompares++;
         $display("FAIL R1: actual=%b expected=000", {cy, ac, ov});
      end
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      vectors++;
      if ({cy, ac, ov} !== 3'b000) begin
         miscompares++;
         $display("FAIL R1: after release actual=%b expected=000", {cy, ac, ov});
      end

      // R2: add / add with carry
      run(5'd1, 8'h0F, 8'h01, "R2");
      run(5'd1, 8'h7F, 8'h01, "R2");
      run(5'd1, 8'hFF, 8'h01, "R2");
      run(5'd2, 8'h10, 8'h20, "R2");
      run(5'd1, 8'h80, 8'h80, "R2");
      run(5'd2, 8'h3F, 8'h40, "R2");
      // R3: subtract with borrow
      wr(3'b000);
      run(5'd3, 8'h00, 8'h01, "R3");
      run(5'd3, 8'h80, 8'h00, "R3");
      run(5'd3, 8'h55, 8'h22, "R3");
      run(5'd3, 8'h7F, 8'hFF, "R3");
      // R4: multiply threshold 255/256, AC kept
      wr(3'b110);
      run(5'd4, 8'd16, 8'd16, "R4");
      run(5'd4, 8'd15, 8'd17, "R4");
      // R5: divide
      wr(3'b100);
      run(5'd5, 8'd9, 8'd0, "R5");
      run(5'd5, 8'd9, 8'd3, "R5");
      // R6: decimal adjust
      wr(3'b010);
      run(5'd6, 8'h12, 8'h00, "R6");
      wr(3'b000);
      run(5'd6, 8'h9A, 8'h00, "R6");
      run(5'd6, 8'h00, 8'h00, "R6");
      wr(3'b000);
      run(5'd6, 8'hFA, 8'h00, "R6");
      wr(3'b001);
      run(5'd6, 8'h45, 8'h00, "R6");
      // R7: rotates
      run(5'd7, 8'h80, 8'h00, "R7");
      run(5'd8, 8'h02, 8'h00, "R7");
      run(5'd8, 8'h01, 8'h00, "R7");
      // R8: set / clear / complement
      wr(3'b011);
      run(5'd9,  8'h00, 8'h00, "R8");
      run(5'd10, 8'h00, 8'h00, "R8");
      run(5'd11, 8'h00, 8'h00, "R8");
      run(5'd11, 8'h00, 8'h00, "R8");
      // R9: bit moves and logic
      step(5'd12, 8'h00, 8'h00, 1'b1, 1'b1, 1'b0, 3'b000, "R9");
      step(5'd13, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 3'b000, "R9");
      step(5'd15, 8'h00, 8'h00, 1'b1, 1'b1, 1'b0, 3'b000, "R9");
      step(5'd14, 8'h00, 8'h00, 1'b1, 1'b1, 1'b0, 3'b000, "R9");
      step(5'd16, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 3'b000, "R9");
      step(5'd14, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 3'b000, "R9");
      step(5'd16, 8'h00, 8'h00, 1'b1, 1'b1, 1'b0, 3'b000, "R9");
      // R10: compare
      run(5'd17, 8'd3, 8'd5, "R10");
      run(5'd17, 8'd5, 8'd3, "R10");
      run(5'd17, 8'd7, 8'd7, "R10");
      run(5'd17, 8'd1, 8'hFF, "R10");
      // R11: register write wins over a retiring instruction
      step(5'd9, 8'h00, 8'h00, 1'b0, 1'b1, 1'b1, 3'b011, "R11");
      step(5'd1, 8'hFF, 8'hFF, 1'b0, 1'b1, 1'b1, 3'b100, "R11");
      // R12: no retire or unknown class leaves flags alone
      wr(3'b010);
      step(5'd9, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 3'b000, "R12");
      run(5'd20, 8'hFF, 8'hFF, "R12");
      run(5'd0, 8'hFF, 8'hFF, "R12");
      run(5'd31, 8'h00, 8'h01, "R12");

      // random sequence across all requirements (R2..R12)
      for (int i = 0; i < 400; i++) begin
         step(5'($urandom_range(0, 21)), 8'($urandom), 8'($urandom),
              1'($urandom), ($urandom_range(0, 7) != 0), ($urandom_range(0, 9) == 0),
              3'($urandom), "R2-mix");
      end

      @(negedge clk);
      retire = 1'b0;
      sfr_we = 1'b0;
      repeat (3) @(posedge clk);
      #2;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule